// File: doc/BRIEF.md
# Parallel-Bus Converter Conversion Sequencer

This block sits on the host side of an 8-bit sampling converter that shares a parallel data bus with the host. A single request with a configuration byte starts a fixed sequence. The block first runs a write cycle that places the byte on the bus and starts a conversion. It then waits out the worst-case conversion time. Last, it runs a read cycle, captures the converted byte and presents it with a one-cycle strobe.

The converter is controlled by two active-low enables, which must both be asserted for any bus operation, and a read/write-select line. Both enables low with the select low starts a write and a conversion. Both enables low with the select high is a read. Any other combination does nothing. Every nanosecond figure is turned into a clock-cycle count, rounded up, from a clock-period parameter. A new request is accepted only while the block is idle.

Top module: `adc_bus_sequencer`

## Requirements
- R1: After reset and whenever idle, both enables are high (`bus_sel_n`=1, `bus_en_n`=1), `bus_rd`=1, `bus_oe`=0, `busy`=0 and `result_valid`=0.
- R2: A write cycle holds `bus_rd`=0 with the configuration byte driven (`bus_oe`=1) for one cycle before both enables fall. It then keeps both enables low for max(ceil(300 ns/T), ceil(200 ns/T)) cycles, which is 75 at T=4 ns.
- R3: After the enables rise at the end of a write, `bus_oe` stays 1, `bus_dout` stays unchanged and `bus_rd` stays 0 for max(1, ceil(10 ns/T)) cycles, which is 3 at T=4 ns.
- R4: Both enables and the select line are never all low for as many as ceil(10 us/T) consecutive cycles (2500 at T=4 ns), so the converter never enters repeated conversion.
- R5: The enables do not fall for a read until at least ceil(10 us/T) cycles after they rose at the end of the write.
- R6: A read has `bus_rd`=1 and `bus_oe`=0 for at least one cycle before both enables fall. The enables then stay low for ceil(250 ns/T) cycles (63 at T=4 ns), and `bus_din` is sampled at the clock edge that ends the last of those cycles. `bus_oe` is never 1 while a read is in progress.
- R7: `result_valid` is a single-cycle pulse that carries the sampled byte on `result`. It rises 1+PW+HOLD+CONV+1+ACC cycles after the edge that accepts `start`, which is 2643 at T=4 ns.
- R8: `busy` rises at the edge that accepts `start` and stays high until the sequence ends. A `start` seen while `busy`=1 is ignored: it causes no second write and does not change the result.
- R9: `bus_sel_n` and `bus_en_n` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion (accepted only when idle) |
| cfg | input | 8 | Configuration byte written at conversion start |
| busy | output | 1 | Sequence in progress |
| result | output | 8 | Converted byte |
| result_valid | output | 1 | One-cycle strobe for `result` |
| bus_sel_n | output | 1 | Active-low bus select enable |
| bus_en_n | output | 1 | Active-low bus chip enable |
| bus_rd | output | 1 | 1 = read, 0 = write/convert |
| bus_oe | output | 1 | Host drives `bus_dout` onto the shared bus |
| bus_dout | output | 8 | Byte driven during the write phase |
| bus_din | input | 8 | Byte read from the shared bus |

## Verification
Every pin is a flop decoded from the next state, so a wrong state or a wrong timer load shows on the bus pins at the very next edge. An early release of the write enables shows as a short low window. A write pulse that runs too long shows as an all-low window. A shortened wait shows as a read that starts while the converter model still reports a conversion in progress. A read that samples too early captures the model's filler byte instead of the result, and any cycle slip moves `result_valid` off its fixed latency.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_CONV_WAIT,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_RD_DONE
  } seq_state_e;

  // Round-up conversion of a nanosecond interval to clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // A running timer only counts down by one or reloads.
  assert_timer_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned PW_CYC   = 75,
  parameter int unsigned HOLD_CYC = 3,
  parameter int unsigned CONV_CYC = 2500,
  parameter int unsigned ACC_CYC  = 63,
  parameter int unsigned CNT_W    = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output seq_state_e state_q,
  output seq_state_e state_d
);
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_done;

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_done)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_WR_SETUP; t_load = 1'b1; t_val = '0;
      end
      ST_WR_SETUP: if (t_done) begin
        state_d = ST_WR_PULSE; t_load = 1'b1; t_val = CNT_W'(PW_CYC - 1);
      end
      ST_WR_PULSE: if (t_done) begin
        state_d = ST_WR_HOLD; t_load = 1'b1; t_val = CNT_W'(HOLD_CYC - 1);
      end
      ST_WR_HOLD: if (t_done) begin
        state_d = ST_CONV_WAIT; t_load = 1'b1; t_val = CNT_W'(CONV_CYC - 1);
      end
      ST_CONV_WAIT: if (t_done) begin
        state_d = ST_RD_SETUP; t_load = 1'b1; t_val = '0;
      end
      ST_RD_SETUP: if (t_done) begin
        state_d = ST_RD_ACCESS; t_load = 1'b1; t_val = CNT_W'(ACC_CYC - 1);
      end
      ST_RD_ACCESS: if (t_done) begin
        state_d = ST_RD_DONE; t_load = 1'b1; t_val = '0;
      end
      ST_RD_DONE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // A request seen outside idle never restarts the write phase.
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && state_q != ST_RD_DONE && start) |=> (state_q != ST_WR_SETUP));
endmodule

// File: rtl/adc_seq_pins.sv
`timescale 1ns/1ps
module adc_seq_pins
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PW_CYC   = 75,
  parameter int unsigned HOLD_CYC = 3,
  parameter int unsigned CONV_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q,
  input  seq_state_e        state_d,
  input  logic [DATA_W-1:0] cfg,
  input  logic [DATA_W-1:0] bus_din,
  output logic              en_n,
  output logic              rd,
  output logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid
);
  logic wr_phase_d, capture;

  assign wr_phase_d = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                      (state_d == ST_WR_HOLD);
  assign capture    = (state_q == ST_RD_ACCESS) && (state_d == ST_RD_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_n         <= 1'b1;
      rd           <= 1'b1;
      oe           <= 1'b0;
      dout         <= '0;
      busy         <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      en_n         <= !((state_d == ST_WR_PULSE) || (state_d == ST_RD_ACCESS));
      rd           <= !wr_phase_d;
      oe           <= wr_phase_d;
      busy         <= (state_d != ST_IDLE);
      result_valid <= capture;
      if (state_q == ST_IDLE && state_d == ST_WR_SETUP) dout <= cfg;
      if (capture) result <= bus_din;
    end
  end

  // Checker counters: consecutive low cycles, and high cycles since a write ended.
  int unsigned low_cnt, gap_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= 0;
      gap_cnt <= 0;
    end else begin
      low_cnt <= en_n ? 0 : low_cnt + 1;
      if (!en_n && !rd)                 gap_cnt <= 0;
      else if (en_n && gap_cnt < CONV_CYC + HOLD_CYC + 4) gap_cnt <= gap_cnt + 1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (en_n && !oe));
  assert_write_width_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(en_n) && !rd) |-> (low_cnt >= PW_CYC));
  assert_data_held_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(en_n) && !rd) |-> (oe && $stable(dout)));
  assert_no_reconvert_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !rd) |-> (low_cnt + 1 < CONV_CYC));
  assert_conv_wait_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_n) && rd) |-> (gap_cnt >= CONV_CYC + HOLD_CYC));
  assert_read_released_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_n) && rd) |-> ($past(rd) && !$past(oe)));
  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (!en_n && rd) |-> !oe);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
endmodule

// File: rtl/adc_bus_sequencer.sv
`timescale 1ns/1ps
module adc_bus_sequencer
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PULSE_NS      = 300,
  parameter int unsigned SETUP_NS      = 200,
  parameter int unsigned HOLD_NS       = 10,
  parameter int unsigned CONV_NS       = 10000,
  parameter int unsigned ACCESS_NS     = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] cfg,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              bus_sel_n,
  output logic              bus_en_n,
  output logic              bus_rd,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int unsigned PW_CYC   = umax(ns_to_cyc(PULSE_NS, CLK_PERIOD_PS),
                                          ns_to_cyc(SETUP_NS, CLK_PERIOD_PS));
  localparam int unsigned HOLD_CYC = umax(1, ns_to_cyc(HOLD_NS, CLK_PERIOD_PS));
  localparam int unsigned CONV_CYC = umax(1, ns_to_cyc(CONV_NS, CLK_PERIOD_PS));
  localparam int unsigned ACC_CYC  = umax(1, ns_to_cyc(ACCESS_NS, CLK_PERIOD_PS));
  localparam int unsigned MAX_CYC  = umax(umax(PW_CYC, CONV_CYC), umax(HOLD_CYC, ACC_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  logic       en_n;

  adc_seq_fsm #(
    .PW_CYC(PW_CYC), .HOLD_CYC(HOLD_CYC), .CONV_CYC(CONV_CYC),
    .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .state_q(state_q), .state_d(state_d)
  );

  adc_seq_pins #(
    .DATA_W(DATA_W), .PW_CYC(PW_CYC), .HOLD_CYC(HOLD_CYC), .CONV_CYC(CONV_CYC)
  ) u_pins (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .cfg(cfg), .bus_din(bus_din), .en_n(en_n), .rd(bus_rd), .oe(bus_oe),
    .dout(bus_dout), .busy(busy), .result(result), .result_valid(result_valid)
  );

  // Both enables share one flop so they can never skew (R9).
  assign bus_sel_n = en_n;
  assign bus_en_n  = en_n;
endmodule

// File: tb/tb_adc_bus_sequencer.sv
`timescale 1ns/1ps
module tb_adc_bus_sequencer;
  localparam int unsigned T_PS = 4000;
  localparam int unsigned PW   = ((300*1000 + T_PS - 1) / T_PS);
  localparam int unsigned HOLD = ((10*1000 + T_PS - 1) / T_PS);
  localparam int unsigned CONV = ((10000*1000 + T_PS - 1) / T_PS);
  localparam int unsigned ACC  = ((250*1000 + T_PS - 1) / T_PS);
  localparam int unsigned LAT  = 1 + PW + HOLD + CONV + 1 + ACC;
  localparam int unsigned NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h3C, 8'h01};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] cfg = '0, bus_din = '0;
  logic busy, result_valid, bus_sel_n, bus_en_n, bus_rd, bus_oe;
  logic [7:0] result, bus_dout;

  always #2 clk = ~clk;

  adc_bus_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .busy(busy),
    .result(result), .result_valid(result_valid), .bus_sel_n(bus_sel_n),
    .bus_en_n(bus_en_n), .bus_rd(bus_rd), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural converter-bus model with protocol monitors.
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r9 = 0;
  int writes = 0, wr_low = 0, rd_low = 0, hold_left = 0, conv_left = 0;
  bit p_wr = 0, p_rd_act = 0, p_rd = 1, p_oe = 0;
  logic [7:0] wr_data = '0, conv_res = '0;

  always @(negedge clk) begin
    if (rst) begin
      wr_low = 0; rd_low = 0; hold_left = 0; conv_left = 0;
      p_wr = 0; p_rd_act = 0; p_rd = 1; p_oe = 0; bus_din = 8'hEE;
    end else begin
      if (conv_left > 0) conv_left--;
      if (bus_sel_n != bus_en_n) v_r9++;
      if (!bus_sel_n && !bus_en_n && !bus_rd) begin
        if (!p_wr) begin
          if (!bus_oe || p_rd || !p_oe) v_r2++;
          wr_data = bus_dout;
        end else if (!bus_oe || bus_dout != wr_data) v_r3++;
        wr_low++;
        if (wr_low >= CONV) v_r4++;
        bus_din = 8'hEE;
      end else if (!bus_sel_n && !bus_en_n && bus_rd) begin
        if (!p_rd_act) begin
          if (!p_rd || p_oe) v_r6++;
          if (conv_left != 0) v_r5++;
          rd_low = 0;
        end
        if (bus_oe) v_r6++;
        rd_low++;
        bus_din = (rd_low >= ACC) ? conv_res : 8'hEE;
      end else begin
        if (p_wr) begin
          if (wr_low < PW) v_r2++;
          conv_res = wr_data ^ 8'hA5;
          conv_left = CONV;
          hold_left = HOLD;
          writes++;
        end
        if (hold_left > 0) begin
          if (!bus_oe || bus_dout != wr_data || bus_rd) v_r3++;
          hold_left--;
        end
        wr_low = 0;
        bus_din = 8'hEE;
      end
      p_wr     = !bus_sel_n && !bus_en_n && !bus_rd;
      p_rd_act = !bus_sel_n && !bus_en_n && bus_rd;
      p_rd     = bus_rd;
      p_oe     = bus_oe;
    end
  end

  task automatic run_conv(input logic [7:0] d, output logic [7:0] r, output int lat);
    @(negedge clk); cfg = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R8 busy after accept", busy, 1);
    lat = 0;
    while (result_valid !== 1'b1 && lat < LAT + 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    r = result;
    @(negedge clk);
    check(result_valid === 1'b0, "R7 single-cycle valid", result_valid, 0);
  endtask

  initial begin
    logic [7:0] r;
    int lat, w0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(bus_sel_n && bus_en_n && bus_rd && !bus_oe && !busy && !result_valid,
          "R1 reset state", {bus_sel_n, bus_en_n, bus_rd, bus_oe, busy, result_valid}, 6'b111000);

    // Table of configuration bytes, expected result = byte ^ A5 from the model.
    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC[i], r, lat);
      check(r == (VEC[i] ^ 8'hA5), "R7 result", r, VEC[i] ^ 8'hA5);
      check(lat == LAT, "R7 latency", lat, LAT);
    end

    // R8: start while busy is ignored.
    w0 = writes;
    @(negedge clk); cfg = 8'h42; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    cfg = 8'h3C; start = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (result_valid !== 1'b1 && lat < LAT + 50) begin @(negedge clk); lat++; end
    check(result == (8'h42 ^ 8'hA5), "R8 result unchanged by busy start", result, 8'h42 ^ 8'hA5);
    repeat (10) @(negedge clk);
    check(writes == w0 + 1, "R8 single write", writes, w0 + 1);
    check(!busy && bus_sel_n, "R1 idle after sequence", busy, 0);

    // R1: reset in the middle of the conversion wait.
    @(negedge clk); cfg = 8'h77; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (500) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(bus_sel_n && bus_en_n && !bus_oe && !busy && bus_rd, "R1 mid-run reset",
          {bus_sel_n, bus_en_n, bus_oe, busy, bus_rd}, 5'b11001);
    rst = 1'b0;
    run_conv(8'hC3, r, lat);
    check(r == (8'hC3 ^ 8'hA5), "R7 result after reset", r, 8'hC3 ^ 8'hA5);
    check(lat == LAT, "R7 latency after reset", lat, LAT);

    check(v_r2 == 0, "R2 write pulse protocol", v_r2, 0);
    check(v_r3 == 0, "R3 write hold", v_r3, 0);
    check(v_r4 == 0, "R4 no repeated conversion", v_r4, 0);
    check(v_r5 == 0, "R5 conversion wait", v_r5, 0);
    check(v_r6 == 0, "R6 read protocol", v_r6, 0);
    check(v_r9 == 0, "R9 enables together", v_r9, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule